// File: doc/BRIEF.md
# ADC Conversion-Clock Tick Generator

This block paces a successive-approximation sequencer. It produces a one-cycle strobe once per conversion-clock period, and a second strobe halfway through each period so that the sequencer can count half periods. The conversion clock comes from one of two places. It can be the block's own clock divided by a power of two. It can also be a free-running, asynchronous RC clock, which the block synchronises and turns into edge strobes.

A 3-bit select code picks the source and the ratio. The codes do not rise in step with the divide ratio. The two codes whose low bits are both one bypass the divider and pick the RC clock. That clock is the only source that keeps running while the chip sleeps. The block reports whether the chosen source survives sleep, so the controller knows whether a conversion may carry on once sleep is requested.

Top module: `adc_tick_gen`

## Requirements
- R1: For a system-clock source, `tick_full` is a single-cycle pulse every N cycles, where N = 2^(2*sel[1:0] + 1 + sel[2]). The codes map as follows: 000 is 2, 100 is 4, 001 is 8, 101 is 16, 010 is 32 and 110 is 64.
- R2: With `sel` held stable, the first `tick_full` is visible after the Nth rising edge of `clk` at which `enable` is high, counting the first such edge as 1.
- R3: `tick_half` is a single-cycle pulse N/2 cycles after each period starts, so the first one is visible after edge N/2. `tick_full` and `tick_half` are never high together.
- R4: When sel[1:0] = 11 (codes 011 and 111) and `enable` is high, `tick_full` pulses once for every rising edge of `rc_clk` and `tick_half` pulses once for every falling edge. The pulse follows the edge through a two-flop synchroniser.
- R5: While `sleep` is high, a system-clock source produces no ticks, and its counter restarts so that the first tick after `sleep` falls comes a full N cycles later. The RC source keeps ticking while `sleep` is high.
- R6: A change of `sel` restarts the divider. The first `tick_full` after the change is visible after edge N+1, counted from the change, and the first `tick_half` after edge N/2+1.
- R7: While `enable` is low, both tick outputs stay low for either source, and the divider is held at its start.
- R8: `sleep_capable` is high one cycle after `sel` holds a code with sel[1:0] = 11, and low one cycle after `sel` holds any other code.
- R9: A synchronous active-high `rst` drives all three outputs low, whatever the other inputs are.
- R10: While a system-clock source is selected, activity on `rc_clk` has no effect on the tick outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the system-clock source for division |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Prescaler enable; when low, no ticks and the counter is cleared |
| sleep | input | 1 | Chip sleep request; stops the system-clock sources |
| sel | input | 3 | Source and divide-ratio select code |
| rc_clk | input | 1 | Asynchronous internal RC clock |
| tick_full | output | 1 | One-cycle strobe at each full conversion-clock period |
| tick_half | output | 1 | One-cycle strobe in the middle of each period |
| sleep_capable | output | 1 | High when the selected source keeps running in sleep |

## Verification
The hardest case to reach from the ports is a counter that was in the middle of a period when the source changes. A stale terminal count must not leak out as an early tick under the new ratio or after sleep ends. The bench lets the divider run part of the way through a short period. It then changes `sel`, or raises `sleep`, at a falling edge, and measures from that change the index of the first `tick_full` and `tick_half` against N+1 and N/2+1. For the RC path, the bench drives `rc_clk` with slow, wide phases. Each edge then passes through the synchroniser on its own, so tick counts can be compared with edge counts exactly, with `sleep` high and with it low.

// File: rtl/adc_tick_pkg.sv
package adc_tick_pkg;

  localparam int SEL_W = 3;

  // Low two select bits both set: the RC clock is the source.
  function automatic logic sel_is_rc(input logic [SEL_W-1:0] s);
    return (s[1:0] == 2'b11);
  endfunction

  // log2 of the divide ratio for a system-clock code.
  function automatic int unsigned sel_div_exp(input logic [SEL_W-1:0] s);
    return 2 * int'(s[1:0]) + 1 + int'(s[2]);
  endfunction

endpackage

// File: rtl/rc_edge_sync.sv
module rc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rc_async,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronised level and sh[STAGES] is its previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-1:0], rc_async};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];

endmodule

// File: rtl/sys_divider.sv
module sys_divider
  import adc_tick_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [SEL_W-1:0] sel,
  output logic             full_hit,
  output logic             half_hit
);
  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic [CNT_W-1:0] mid;
  logic             changed;
  logic             run;
  int unsigned      e;

  always_comb begin
    e       = sel_div_exp(sel);
    last    = CNT_W'((1 << e) - 1);
    mid     = CNT_W'((1 << (e - 1)) - 1);
    changed = (sel != sel_q);
    run     = run_en && !changed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      cnt   <= '0;
    end else begin
      sel_q <= sel;
      if (!run)             cnt <= '0;
      else if (cnt == last) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
    end
  end

  assign full_hit = run && (cnt == last);
  assign half_hit = run && (cnt == mid);

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == sel_q) |-> (cnt <= last));

  // R6
  sel_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != sel_q) |=> (cnt == '0));

endmodule

// File: rtl/tick_out_stage.sv
module tick_out_stage (
  input  logic clk,
  input  logic rst,
  input  logic rc_mode,
  input  logic enable,
  input  logic div_full,
  input  logic div_half,
  input  logic rc_rise,
  input  logic rc_fall,
  output logic tick_full,
  output logic tick_half,
  output logic sleep_capable
);
  logic full_d;
  logic half_d;

  always_comb begin
    if (rc_mode) begin
      full_d = enable && rc_rise;
      half_d = enable && rc_fall;
    end else begin
      full_d = div_full;
      half_d = div_half;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_full     <= 1'b0;
      tick_half     <= 1'b0;
      sleep_capable <= 1'b0;
    end else begin
      tick_full     <= full_d;
      tick_half     <= half_d;
      sleep_capable <= rc_mode;
    end
  end

endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen
  import adc_tick_pkg::*;
#(
  parameter int MAX_EXP     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             sleep,
  input  logic [SEL_W-1:0] sel,
  input  logic             rc_clk,
  output logic             tick_full,
  output logic             tick_half,
  output logic             sleep_capable
);
  localparam int CNT_W = MAX_EXP;

  logic rc_mode;
  logic run_en;
  logic div_full;
  logic div_half;
  logic rc_rise;
  logic rc_fall;

  assign rc_mode = sel_is_rc(sel);
  assign run_en  = enable && !sleep && !rc_mode;

  sys_divider #(.CNT_W(CNT_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .sel      (sel),
    .full_hit (div_full),
    .half_hit (div_half)
  );

  rc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .rc_async (rc_clk),
    .rise     (rc_rise),
    .fall     (rc_fall)
  );

  tick_out_stage u_out (
    .clk           (clk),
    .rst           (rst),
    .rc_mode       (rc_mode),
    .enable        (enable),
    .div_full      (div_full),
    .div_half      (div_half),
    .rc_rise       (rc_rise),
    .rc_fall       (rc_fall),
    .tick_full     (tick_full),
    .tick_half     (tick_half),
    .sleep_capable (sleep_capable)
  );

  // R3
  full_half_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(tick_full && tick_half));

  // R5
  sleep_sys_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(sleep) && !$past(rc_mode)) |-> (!tick_full && !tick_half));

  // R7
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!tick_full && !tick_half));

  // R8
  sleep_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    sel_is_rc(sel) |=> sleep_capable);

  // R8
  sleep_flag_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_is_rc(sel) |=> !sleep_capable);

endmodule

// File: tb/sim_adc_tick_gen.sv
module sim_adc_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic       clk = 1'b0;
  logic       rst;
  logic       enable;
  logic       sleep;
  logic [2:0] sel;
  logic       rc_clk;
  logic       tick_full;
  logic       tick_half;
  logic       sleep_capable;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_tick_gen u0 (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .sleep         (sleep),
    .sel           (sel),
    .rc_clk        (rc_clk),
    .tick_full     (tick_full),
    .tick_half     (tick_half),
    .sleep_capable (sleep_capable)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Run a window and record the index of the first tick and the tick totals.
  task automatic watch(input int cycles, input bit wiggle_rc,
                       output int ff, output int fh, output int nf, output int nh);
    ff = 0; fh = 0; nf = 0; nh = 0;
    for (int i = 1; i <= cycles; i++) begin
      @(negedge clk);
      if (tick_full) begin nf++; if (ff == 0) ff = i; end
      if (tick_half) begin nh++; if (fh == 0) fh = i; end
      if (wiggle_rc) rc_clk = ~rc_clk;
    end
  endtask

  task automatic rc_periods(input int k, output int nf, output int nh);
    nf = 0; nh = 0;
    for (int p = 0; p < k; p++) begin
      rc_clk = 1'b1;
      for (int j = 0; j < 10; j++) begin
        @(negedge clk);
        if (tick_full) nf++;
        if (tick_half) nh++;
        if (j == 4) rc_clk = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ff, fh, nf, nh, n;
    rst = 1'b1; enable = 1'b1; sleep = 1'b0; sel = 3'b011; rc_clk = 1'b0;
    repeat (3) @(negedge clk);
    // R9: outputs are low during reset
    chk("R9", "tick_full in reset", int'(tick_full), 0);
    chk("R9", "tick_half in reset", int'(tick_half), 0);
    chk("R9", "sleep_capable in reset", int'(sleep_capable), 0);
    rst = 1'b0; enable = 1'b0;

    // R8: sleep_capable flag for every code
    for (int c = 0; c < 8; c++) begin
      sel = 3'(c);
      @(negedge clk);
      chk("R8", $sformatf("sleep_capable code %0d", c), int'(sleep_capable),
          (c % 4 == 3) ? 1 : 0);
    end

    // R1 R2 R3 R10: sweep every system-clock code while rc_clk toggles
    for (int c = 0; c < 8; c++) begin
      if (c % 4 == 3) continue;
      n = 1 << (2 * (c % 4) + 1 + c / 4);
      enable = 1'b0; sel = 3'(c); rc_clk = 1'b0;
      repeat (3) @(negedge clk);
      enable = 1'b1;
      watch(4 * n, 1'b1, ff, fh, nf, nh);
      chk("R2", $sformatf("first full code %0d", c), ff, n);
      chk("R3", $sformatf("first half code %0d", c), fh, n / 2);
      chk("R1", $sformatf("full count code %0d", c), nf, 4);
      chk("R10", $sformatf("half count code %0d", c), nh, 4);
      enable = 1'b0; rc_clk = 1'b0;
      @(negedge clk);
    end

    // R6: a select change in mid-period restarts the divider
    sel = 3'b000; enable = 1'b1;
    repeat (7) @(negedge clk);
    sel = 3'b100;
    watch(12, 1'b0, ff, fh, nf, nh);
    chk("R6", "first full after change", ff, 5);
    chk("R6", "first half after change", fh, 3);
    chk("R6", "full count after change", nf, 2);

    // R5: system source goes quiet in sleep and restarts a full period later
    sel = 3'b010;
    repeat (10) @(negedge clk);
    sleep = 1'b1;
    watch(100, 1'b0, ff, fh, nf, nh);
    chk("R5", "sys full in sleep", nf, 0);
    chk("R5", "sys half in sleep", nh, 0);
    sleep = 1'b0;
    watch(40, 1'b0, ff, fh, nf, nh);
    chk("R5", "first full after sleep", ff, 32);

    // R4 R5: RC source keeps ticking in sleep
    sel = 3'b011; sleep = 1'b1; rc_clk = 1'b0;
    repeat (4) @(negedge clk);
    rc_periods(6, nf, nh);
    chk("R4", "rc full count in sleep", nf, 6);
    chk("R4", "rc half count in sleep", nh, 6);
    sel = 3'b111; sleep = 1'b0;
    rc_periods(4, nf, nh);
    chk("R4", "rc full count code 7", nf, 4);
    chk("R4", "rc half count code 7", nh, 4);

    // R7: disabled means no ticks for either source
    enable = 1'b0; sel = 3'b011;
    rc_periods(3, nf, nh);
    chk("R7", "rc full while disabled", nf, 0);
    chk("R7", "rc half while disabled", nh, 0);
    sel = 3'b000;
    watch(40, 1'b0, ff, fh, nf, nh);
    chk("R7", "sys full while disabled", nf, 0);
    enable = 1'b1;
    watch(8, 1'b0, ff, fh, nf, nh);
    chk("R7", "first full after enable", ff, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule